// File: doc/BRIEF.md
# Inverter PWM status flag unit

This block is the status register of a three-phase inverter PWM timer. It watches three complementary output pairs for shoot-through: a normal phase and its paired inverted phase active at the same time. When that happens it latches a sticky error flag and emits a one-cycle error interrupt. It also reports whether the triangle sub-counter is rising or falling. A third flag tracks a pending buffered reload, and while it is set the block withholds the write enable that gates the compare registers and option register 1.

The CPU reads all three flags as one byte and writes it either whole or one bit at a time. Only the error flag reacts to writes, and only a written 0 clears it. Dropping the timer count enable clears the whole register, in the same way as reset. Waveform generation and the reload transfer itself are outside this block.

Top module: `inv_pwm_flags`

## Requirements
- R1: The read byte is {5'b0, err, dir, rsf}: bit 0 is the reload-pending flag, bit 1 is the direction flag, bit 2 is the shoot-through error flag, and bits 7..3 read 0.
- R2: Reset, or `count_en` low at a clock edge, drives all three flags and `err_irq` to 0.
- R3: With `det_en` nonzero, the error flag is set one edge after any pair is active together. Phase k is `phase_out[k-1]`, and the pairs are (bit0,bit1), (bit2,bit3) and (bit4,bit5). Overlap across different pairs does not count.
- R4: With `det_en` = 000, simultaneous activity leaves the error flag and `err_irq` at 0.
- R5: `err_irq` is high for exactly one cycle, in the same cycle the error flag first reads 1 after the detection condition rises. A condition that stays present gives no further pulse.
- R6: A byte write with bit 2 = 0, or a single-bit write to bit 2 with value 0, clears the error flag. Writing 1 has no effect. If detection is present in the same cycle as the clear, the flag stays 1.
- R7: In triangle mode the direction flag becomes 0 when the sub-counter equals 0, or when it rises within 2..period−2. It becomes 1 when the sub-counter equals the period, or when it falls within period−2..2. At the values 1 and period−1, and with an unchanged count, it holds.
- R8: With `tri_mode` low the direction flag reads 0. CPU writes never change it.
- R9: The reload-pending flag is set one edge after `ccr1_wr` and cleared one edge after `reload_done`. If both occur in the same cycle, set wins. CPU writes never change it.
- R10: `cmp_wr_en` is the inverse of the reload-pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Timer count enable; low clears the register |
| wr_en | input | 1 | CPU write strobe |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_sel | input | 3 | Bit index for a single-bit write |
| wdata | input | 8 | Write data; bit 0 carries the value for single-bit writes |
| rdata | output | 8 | Register read value |
| phase_out | input | 6 | Phase outputs 1..6 on bits 0..5 |
| det_en | input | 3 | Shoot-through detection enable field |
| tri_mode | input | 1 | High-accuracy triangle PWM mode active |
| sub_cnt | input | CNT_W | Sub-counter value |
| period | input | CNT_W | Sub-counter period (peak value) |
| ccr1_wr | input | 1 | Write to compare register 1 |
| reload_done | input | 1 | Buffered reload completed |
| err_irq | output | 1 | Error interrupt pulse |
| cmp_wr_en | output | 1 | Write enable for compare registers 0–5 and option register 1 |

## Verification
Every flag and `err_irq` is registered. A stimulus applied just after a rising edge is therefore visible at the outputs right after the next edge, and `cmp_wr_en` follows the reload flag with no extra delay. The bench drives inputs 1 ns after an edge, advances exactly one edge per step, and samples another 1 ns later. The sub-counter table gives one value per step, and each check compares the direction flag produced by that value against the previous one. Interrupt checks look at the first step after the rise and at the step that follows it.

// File: rtl/inv_pwm_flags.sv
module inv_pwm_flags #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [5:0]       phase_out,
  input  logic [2:0]       det_en,
  input  logic             tri_mode,
  input  logic [CNT_W-1:0] sub_cnt,
  input  logic [CNT_W-1:0] period,
  input  logic             ccr1_wr,
  input  logic             reload_done,
  output logic             err_irq,
  output logic             cmp_wr_en
);
  localparam logic [CNT_W-1:0] LOW_EDGE = CNT_W'(2);

  logic             err_q, dir_q, rsf_q, det_q, irq_q;
  logic [CNT_W-1:0] prev_cnt;

  logic [2:0] pair_hit;
  always_comb
    for (int p = 0; p < 3; p++) pair_hit[p] = phase_out[2*p] & phase_out[2*p+1];

  wire det       = count_en && (det_en != 3'b000) && (|pair_hit);
  wire err_clear = wr_en && (wr_bit ? (wr_sel == 3'd2 && !wdata[0]) : !wdata[2]);

  wire [CNT_W-1:0] hi_edge = period - LOW_EDGE;
  wire in_mid  = (sub_cnt >= LOW_EDGE) && (sub_cnt <= hi_edge);
  wire rising  = sub_cnt > prev_cnt;
  wire falling = sub_cnt < prev_cnt;

  logic dir_nxt;
  always_comb begin
    dir_nxt = dir_q;
    if (!tri_mode)                dir_nxt = 1'b0;
    else if (sub_cnt == '0)       dir_nxt = 1'b0;
    else if (sub_cnt == period)   dir_nxt = 1'b1;
    else if (in_mid && rising)    dir_nxt = 1'b0;
    else if (in_mid && falling)   dir_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      dir_q    <= 1'b0;
      rsf_q    <= 1'b0;
      det_q    <= 1'b0;
      irq_q    <= 1'b0;
      prev_cnt <= '0;
    end else if (!count_en) begin
      err_q    <= 1'b0;
      dir_q    <= 1'b0;
      rsf_q    <= 1'b0;
      det_q    <= 1'b0;
      irq_q    <= 1'b0;
      prev_cnt <= sub_cnt;
    end else begin
      det_q    <= det;
      irq_q    <= det && !det_q;
      prev_cnt <= sub_cnt;
      dir_q    <= dir_nxt;
      if (det)            err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
      if (ccr1_wr)          rsf_q <= 1'b1;
      else if (reload_done) rsf_q <= 1'b0;
    end
  end

  assign rdata     = {5'b00000, err_q, dir_q, rsf_q};
  assign err_irq   = irq_q;
  assign cmp_wr_en = !rsf_q;

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> (rdata == 8'h00 && !err_irq));
  a_r5_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> rdata[2]);
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en == 3'b000 && !rdata[2]) |=> !err_irq);
  a_r8_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_mode |=> !rdata[1]);
  a_r9_reload_set: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && ccr1_wr) |=> rdata[0]);
  a_r9_reload_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && reload_done && !ccr1_wr) |=> !rdata[0]);
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en != rdata[0]);
endmodule

// File: tb/inv_pwm_flags_tb_top.sv
module inv_pwm_flags_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, count_en, wr_en, wr_bit, tri_mode, ccr1_wr, reload_done;
  logic [2:0] wr_sel, det_en;
  logic [7:0] wdata, rdata;
  logic [5:0] phase_out;
  logic [15:0] sub_cnt, period;
  logic err_irq, cmp_wr_en;

  int checks = 0, errors = 0;
  bit done = 0;

  inv_pwm_flags #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en), .wr_bit(wr_bit),
    .wr_sel(wr_sel), .wdata(wdata), .rdata(rdata), .phase_out(phase_out),
    .det_en(det_en), .tri_mode(tri_mode), .sub_cnt(sub_cnt), .period(period),
    .ccr1_wr(ccr1_wr), .reload_done(reload_done), .err_irq(err_irq), .cmp_wr_en(cmp_wr_en));

  // {sub_cnt, expected dir}, period = 10
  localparam logic [16:0] DIR_TAB [24] = '{
    {16'd0,1'b0}, {16'd1,1'b0}, {16'd2,1'b0}, {16'd3,1'b0}, {16'd5,1'b0}, {16'd8,1'b0},
    {16'd9,1'b0}, {16'd10,1'b1}, {16'd9,1'b1}, {16'd8,1'b1}, {16'd6,1'b1}, {16'd3,1'b1},
    {16'd2,1'b1}, {16'd1,1'b1}, {16'd0,1'b0}, {16'd1,1'b0}, {16'd2,1'b0}, {16'd4,1'b0},
    {16'd8,1'b0}, {16'd9,1'b0}, {16'd9,1'b0}, {16'd10,1'b1}, {16'd10,1'b1}, {16'd7,1'b1}};

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; ccr1_wr = 0; reload_done = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; count_en = 1; wr_en = 0; wr_bit = 0; wr_sel = 0; wdata = 0;
    phase_out = 0; det_en = 0; tri_mode = 0; sub_cnt = 0; period = 16'd10;
    ccr1_wr = 0; reload_done = 0;
    #22;
    chk("R2 reset rdata", rdata, 8'h00);
    chk("R10 reset cmp_wr_en", cmp_wr_en, 1);
    rst_n = 1;
    step();

    // R7: direction table walk
    tri_mode = 1;
    foreach (DIR_TAB[i]) begin
      sub_cnt = DIR_TAB[i][16:1];
      step();
      chk($sformatf("R7 dir idx %0d", i), rdata[1], DIR_TAB[i][0]);
    end

    // R8: leaving triangle mode forces 0; write cannot set it
    tri_mode = 0; sub_cnt = 16'd5;
    step();
    chk("R8 dir outside mode", rdata[1], 0);
    wr_en = 1; wr_bit = 0; wdata = 8'hFF;
    step();
    chk("R8 R1 byte write of FF", rdata, 8'h00);

    // R3/R5: pair overlap
    det_en = 3'b001; phase_out = 6'b000011;
    step();
    chk("R3 err set", rdata[2], 1);
    chk("R5 irq pulse", err_irq, 1);
    chk("R1 layout with err", rdata, 8'h04);
    step();
    chk("R5 irq single", err_irq, 0);
    // R6: clear while detection present -> stays set
    wr_en = 1; wr_bit = 0; wdata = 8'h00;
    step();
    chk("R6 detect wins", rdata[2], 1);
    chk("R5 no repulse", err_irq, 0);
    phase_out = 0;
    wr_en = 1; wr_bit = 1; wr_sel = 3'd2; wdata = 8'h01;
    step();
    chk("R6 write 1 no effect", rdata[2], 1);
    wr_en = 1; wr_bit = 1; wr_sel = 3'd2; wdata = 8'h00;
    step();
    chk("R6 bit clear", rdata[2], 0);

    // R3: cross-pair overlap ignored
    phase_out = 6'b001001;
    step();
    chk("R3 cross pair", rdata[2], 0);
    phase_out = 6'b110000; det_en = 3'b100;
    step();
    chk("R3 third pair", rdata[2], 1);
    chk("R5 third pair irq", err_irq, 1);
    phase_out = 0; wr_en = 1; wr_bit = 0; wdata = 8'h00;
    step();
    chk("R6 byte clear", rdata[2], 0);

    // R4: detection disabled
    det_en = 3'b000; phase_out = 6'b001100;
    step();
    chk("R4 disabled flag", rdata[2], 0);
    chk("R4 disabled irq", err_irq, 0);
    phase_out = 0;

    // R9/R10: reload pending
    ccr1_wr = 1;
    step();
    chk("R9 set", rdata[0], 1);
    chk("R10 locked", cmp_wr_en, 0);
    wr_en = 1; wr_bit = 1; wr_sel = 3'd0; wdata = 8'h00;
    step();
    chk("R9 write ignored", rdata[0], 1);
    ccr1_wr = 1; reload_done = 1;
    step();
    chk("R9 set wins", rdata[0], 1);
    reload_done = 1;
    step();
    chk("R9 cleared", rdata[0], 0);
    chk("R10 unlocked", cmp_wr_en, 1);

    // R2: count enable low clears everything
    ccr1_wr = 1; det_en = 3'b010; phase_out = 6'b001100; tri_mode = 1; sub_cnt = 16'd10;
    step();
    chk("R2 preload", rdata, 8'h07);
    count_en = 0;
    step();
    chk("R2 disable clears", rdata, 8'h00);
    chk("R2 disable irq", err_irq, 0);

    done = 1;
    finish_run();
  end
endmodule